// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit logical address into a physical address by reading a two-level page table held in memory. A requester offers one address at a time, with a flag that marks a write. While the walker is idle it takes the address and splits it into three fields. The top 12 bits index the outer table, the next 10 bits index an inner table, and the low 10 bits are the offset within the page. The outer index is first compared with a table-length value, and an index that is too large traps at once. Otherwise the walker makes two reads on a simple request/response memory port, one after the other: the outer entry first, then the inner entry that the outer entry points to.

Each table entry is 32 bits wide. Bit 0 marks the entry valid and bit 1 marks the page writable. Bits 31:10 hold a 1 KB-aligned base: an inner-table base in an outer entry, or a frame base in an inner entry. The result is one cycle of a done pulse with the physical address, or one cycle of a fault pulse with a cause code and a protection flag. Only one walk runs at a time. A translation cache can sit beside the walker and call it on a miss.

Top module: `pt_walker`

## Requirements
- R1: While idle, `reqReady` is 1, and a request is taken at a clock edge where `reqValid` and `reqReady` are both 1.
- R2: If the outer index (address bits 31:20) is greater than or equal to `tableLen`, no memory read is issued. In the cycle after acceptance, `faultValid` is 1 with `faultCode` 01 and `faultProt` 0.
- R3: Otherwise, in the cycle after acceptance, `memReqValid` is 1 for one cycle with `memReqAddr` = `tableBase` + 4 × outer index.
- R4: If the outer entry returned has bit 0 clear, no second read is issued. In the cycle after the response, `faultValid` is 1 with `faultCode` 10 and `faultProt` 0.
- R5: If the outer entry has bit 0 set, the second read is issued in the cycle after the response, with `memReqAddr` = {outer entry bits 31:10, ten zero bits} + 4 × inner index (address bits 19:10).
- R6: If the inner entry has bit 0 clear, in the cycle after the response `faultValid` is 1 with `faultCode` 11 and `faultProt` 0.
- R7: If the inner entry is valid but has bit 1 clear, a write request faults in the cycle after the response with `faultCode` 11 and `faultProt` 1. A read request of the same page completes normally.
- R8: A valid inner entry that passes the protection check gives, in the cycle after the response, `doneValid` for exactly one cycle with `donePaddr` = {inner entry bits 31:10, address bits 9:0}.
- R9: From acceptance until the done or fault pulse, `reqReady` is 0 and `reqValid` is ignored. `reqReady` returns to 1 in the cycle after the pulse.
- R10: `tableBase`, `tableLen` and the write flag are sampled only at acceptance. Changes to them during a walk have no effect on that walk.
- R11: A `memRespValid` that arrives while no read is awaiting its response is ignored.
- R12: While `rstN` is 0, `reqReady` is 1 and `memReqValid`, `doneValid` and `faultValid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request offered |
| reqVaddr | input | 32 | Logical address to translate |
| reqWrite | input | 1 | 1 when the access is a write |
| tableBase | input | 32 | Byte address of the outer table |
| tableLen | input | 13 | Number of outer entries (0 to 4096) |
| reqReady | output | 1 | Walker idle, request can be taken |
| memReqValid | output | 1 | Memory read request, one cycle |
| memReqAddr | output | 32 | Byte address of the entry to read |
| memRespValid | input | 1 | Read data present |
| memRespData | input | 32 | Entry read from memory |
| doneValid | output | 1 | Translation succeeded, one cycle |
| donePaddr | output | 32 | Physical address, valid with doneValid |
| faultValid | output | 1 | Translation trapped, one cycle |
| faultCode | output | 2 | 01 length, 10 outer invalid, 11 inner invalid or protection |
| faultProt | output | 1 | Fault was a write to a read-only page |

## Verification
Two groups of events can meet in one cycle. A new request, or changed base and length values, can arrive while a walk is in flight. A stray memory response can arrive in a cycle where no read is outstanding: during the accept cycle, a read-issue cycle, or the done or fault cycle. The bench drives both continuously. It holds `reqValid` high with a garbage address during every busy cycle, swaps `tableBase` and `tableLen` to junk, and asserts `memRespValid` with all-ones data on odd cycles outside the wait windows. A behavioural model then compares every output on every clock. Any acceptance, address change or early state change that results from these collisions shows up as a mismatch in that cycle.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_OUTER,
    ST_WT_OUTER,
    ST_RD_INNER,
    ST_WT_INNER,
    ST_DONE,
    ST_FAULT
  } walkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic captureReq;
    logic captureOuter;
    logic captureInner;
    logic selInner;
  } dpCtl_t;

  localparam logic [1:0] FC_NONE   = 2'b00;
  localparam logic [1:0] FC_LENGTH = 2'b01;
  localparam logic [1:0] FC_OUTER  = 2'b10;
  localparam logic [1:0] FC_INNER  = 2'b11;

  localparam int PTE_VALID_BIT = 0;
  localparam int PTE_WRITE_BIT = 1;

endpackage

// File: rtl/pt_walker_dp.sv
module pt_walker_dp
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int OUTER_W     = 12,
  parameter int INNER_W     = 10,
  parameter int OFF_W       = 10,
  parameter int ENTRY_SHIFT = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             ctl,
  input  logic [ADDR_W-1:0]  reqVaddr,
  input  logic [ADDR_W-1:0]  tableBase,
  input  logic [OUTER_W:0]   tableLen,
  input  logic [ADDR_W-1:0]  memRespData,
  output logic               lenViolation,
  output logic               entValid,
  output logic               entWritable,
  output logic [ADDR_W-1:0]  memReqAddr,
  output logic [ADDR_W-1:0]  donePaddr
);

  localparam int FRAME_W = ADDR_W - OFF_W;
  localparam int P2_LSB  = OFF_W;
  localparam int P1_LSB  = OFF_W + INNER_W;

  logic [ADDR_W-1:0]  vaddrQ;
  logic [ADDR_W-1:0]  baseQ;
  logic [FRAME_W-1:0] outerFrameQ;
  logic [FRAME_W-1:0] innerFrameQ;

  logic [OUTER_W-1:0] reqP1;
  logic [OUTER_W-1:0] p1Q;
  logic [INNER_W-1:0] p2Q;
  logic [OFF_W-1:0]   offQ;
  logic [ADDR_W-1:0]  outerAddr;
  logic [ADDR_W-1:0]  innerAddr;
  logic               unusedRespBits;

  assign reqP1        = reqVaddr[P1_LSB +: OUTER_W];
  assign lenViolation = {1'b0, reqP1} >= tableLen;

  assign entValid       = memRespData[PTE_VALID_BIT];
  assign entWritable    = memRespData[PTE_WRITE_BIT];
  assign unusedRespBits = ^memRespData[OFF_W-1:PTE_WRITE_BIT+1];

  assign p1Q  = vaddrQ[P1_LSB +: OUTER_W];
  assign p2Q  = vaddrQ[P2_LSB +: INNER_W];
  assign offQ = vaddrQ[OFF_W-1:0];

  assign outerAddr  = baseQ + (ADDR_W'(p1Q) << ENTRY_SHIFT);
  assign innerAddr  = {outerFrameQ, {OFF_W{1'b0}}} + (ADDR_W'(p2Q) << ENTRY_SHIFT);
  assign memReqAddr = ctl.selInner ? innerAddr : outerAddr;
  assign donePaddr  = {innerFrameQ, offQ};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaddrQ      <= '0;
      baseQ       <= '0;
      outerFrameQ <= '0;
      innerFrameQ <= '0;
    end else begin
      if (ctl.captureReq) begin
        vaddrQ <= reqVaddr;
        baseQ  <= tableBase;
      end
      if (ctl.captureOuter) outerFrameQ <= memRespData[ADDR_W-1:OFF_W];
      if (ctl.captureInner) innerFrameQ <= memRespData[ADDR_W-1:OFF_W];
    end
  end

endmodule

// File: rtl/pt_walker_ctrl.sv
module pt_walker_ctrl
  import pt_walker_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       memRespValid,
  input  logic       lenViolation,
  input  logic       entValid,
  input  logic       entWritable,
  output dpCtl_t     ctl,
  output logic       reqReady,
  output logic       memReqValid,
  output logic       doneValid,
  output logic       faultValid,
  output logic [1:0] faultCode,
  output logic       faultProt
);

  walkState_e state, stateNext;
  logic       wrQ;
  logic [1:0] codeQ, codeNext;
  logic       protQ, protNext;

  always_comb begin
    stateNext = state;
    codeNext  = codeQ;
    protNext  = protQ;
    ctl       = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.captureReq = 1'b1;
          if (lenViolation) begin
            stateNext = ST_FAULT;
            codeNext  = FC_LENGTH;
            protNext  = 1'b0;
          end else begin
            stateNext = ST_RD_OUTER;
          end
        end
      end
      ST_RD_OUTER: stateNext = ST_WT_OUTER;
      ST_WT_OUTER: begin
        if (memRespValid) begin
          if (!entValid) begin
            stateNext = ST_FAULT;
            codeNext  = FC_OUTER;
            protNext  = 1'b0;
          end else begin
            ctl.captureOuter = 1'b1;
            stateNext        = ST_RD_INNER;
          end
        end
      end
      ST_RD_INNER: begin
        ctl.selInner = 1'b1;
        stateNext    = ST_WT_INNER;
      end
      ST_WT_INNER: begin
        ctl.selInner = 1'b1;
        if (memRespValid) begin
          ctl.captureInner = 1'b1;
          if (!entValid || (wrQ && !entWritable)) begin
            stateNext = ST_FAULT;
            codeNext  = FC_INNER;
            protNext  = entValid;
          end else begin
            stateNext = ST_DONE;
          end
        end
      end
      ST_DONE:  stateNext = ST_IDLE;
      ST_FAULT: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      wrQ   <= 1'b0;
      codeQ <= FC_NONE;
      protQ <= 1'b0;
    end else begin
      state <= stateNext;
      codeQ <= codeNext;
      protQ <= protNext;
      if (ctl.captureReq) wrQ <= reqWrite;
    end
  end

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = (state == ST_RD_OUTER) || (state == ST_RD_INNER);
  assign doneValid   = (state == ST_DONE);
  assign faultValid  = (state == ST_FAULT);
  assign faultCode   = faultValid ? codeQ : FC_NONE;
  assign faultProt   = faultValid & protQ;

  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  assert_len_trap_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && lenViolation) |=> (faultValid && faultCode == FC_LENGTH && !memReqValid));

  assert_read_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);

  assert_outer_trap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WT_OUTER && memRespValid && !entValid) |=> (faultValid && faultCode == FC_OUTER));

  assert_prot_code_R7: assert property (@(posedge clk) disable iff (!rstN)
    faultProt |-> (faultValid && faultCode == FC_INNER));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> (!doneValid && reqReady));

  assert_fault_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |=> (!faultValid && reqReady));

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int OUTER_W     = 12,
  parameter int INNER_W     = 10,
  parameter int OFF_W       = 10,
  parameter int ENTRY_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] tableBase,
  input  logic [OUTER_W:0]  tableLen,
  output logic              reqReady,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRespValid,
  input  logic [ADDR_W-1:0] memRespData,
  output logic              doneValid,
  output logic [ADDR_W-1:0] donePaddr,
  output logic              faultValid,
  output logic [1:0]        faultCode,
  output logic              faultProt
);

  dpCtl_t ctl;
  logic   lenViolation;
  logic   entValid;
  logic   entWritable;

  pt_walker_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqWrite     (reqWrite),
    .memRespValid (memRespValid),
    .lenViolation (lenViolation),
    .entValid     (entValid),
    .entWritable  (entWritable),
    .ctl          (ctl),
    .reqReady     (reqReady),
    .memReqValid  (memReqValid),
    .doneValid    (doneValid),
    .faultValid   (faultValid),
    .faultCode    (faultCode),
    .faultProt    (faultProt)
  );

  pt_walker_dp #(
    .ADDR_W      (ADDR_W),
    .OUTER_W     (OUTER_W),
    .INNER_W     (INNER_W),
    .OFF_W       (OFF_W),
    .ENTRY_SHIFT (ENTRY_SHIFT)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .reqVaddr     (reqVaddr),
    .tableBase    (tableBase),
    .tableLen     (tableLen),
    .memRespData  (memRespData),
    .lenViolation (lenViolation),
    .entValid     (entValid),
    .entWritable  (entWritable),
    .memReqAddr   (memReqAddr),
    .donePaddr    (donePaddr)
  );

endmodule

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [31:0] reqVaddr;
  logic        reqWrite;
  logic [31:0] tableBase;
  logic [12:0] tableLen;
  logic        reqReady;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic        memRespValid;
  logic [31:0] memRespData;
  logic        doneValid;
  logic [31:0] donePaddr;
  logic        faultValid;
  logic [1:0]  faultCode;
  logic        faultProt;

  always #2.5 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr), .reqWrite(reqWrite),
    .tableBase(tableBase), .tableLen(tableLen), .reqReady(reqReady),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr), .memRespValid(memRespValid),
    .memRespData(memRespData), .doneValid(doneValid), .donePaddr(donePaddr),
    .faultValid(faultValid), .faultCode(faultCode), .faultProt(faultProt)
  );

  typedef struct {
    logic [31:0] va;
    logic        wr;
    logic [31:0] base;
    logic [12:0] len;
    int          dly;
  } walk_t;

  walk_t             reqQ[$];
  walk_t             cur;
  bit   [31:0]       mem [bit [31:0]];
  int                errors = 0;
  int                checks = 0;
  int                phase  = 0;
  int                cnt    = 0;
  int                cyc    = 0;
  logic [31:0]       outerEnt, ent, expAddr, expPaddr;
  logic [1:0]        expCode;
  logic              expProt;
  string             faultTag;

  function automatic logic [31:0] va(input int p1, input int p2, input int d);
    return {p1[11:0], p2[9:0], d[9:0]};
  endfunction

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic push(input logic [31:0] a, input logic w, input logic [31:0] b, input logic [12:0] l, input int d);
    walk_t t;
    t.va = a; t.wr = w; t.base = b; t.len = l; t.dly = d;
    reqQ.push_back(t);
  endtask

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqVaddr = '0; reqWrite = 1'b0;
    tableBase = '0; tableLen = '0; memRespValid = 1'b0; memRespData = '0;

    // table images: entry bit0 valid, bit1 writable, bits 31:10 base
    mem[32'h0001_0000 + 3*4]    = 32'h0002_0401;
    mem[32'h0002_0400 + 5*4]    = 32'h00AB_C403;
    mem[32'h0002_0400 + 6*4]    = 32'h00AB_D401;
    mem[32'h0002_0400 + 7*4]    = 32'h00AB_E402;
    mem[32'h0001_0000 + 4*4]    = 32'h0003_0400;
    mem[32'h0001_0000 + 15*4]   = 32'h0004_0001;
    mem[32'h0004_0000 + 1023*4] = 32'h1234_5C03;
    mem[32'h0008_0000 + 4095*4] = 32'h0005_0001;
    mem[32'h0005_0000]          = 32'hFFFF_FC01;

    push(va(3, 5, 'h2AB),   1'b0, 32'h0001_0000, 13'd16,   0); // R8 read ok
    push(va(3, 5, 'h2AB),   1'b1, 32'h0001_0000, 13'd16,   2); // R8 write ok
    push(va(3, 6, 'h000),   1'b1, 32'h0001_0000, 13'd16,   1); // R7 write to read-only
    push(va(3, 6, 'h3FF),   1'b0, 32'h0001_0000, 13'd16,   3); // R7 read of read-only
    push(va(3, 7, 'h010),   1'b0, 32'h0001_0000, 13'd16,   0); // R6 inner invalid
    push(va(4, 0, 'h000),   1'b0, 32'h0001_0000, 13'd16,   1); // R4 outer invalid
    push(va(16, 0, 'h000),  1'b0, 32'h0001_0000, 13'd16,   0); // R2 index equals length
    push(va(15, 1023, 'h155), 1'b1, 32'h0001_0000, 13'd16, 1); // R2 last legal index
    push(va(0, 0, 'h000),   1'b0, 32'h0001_0000, 13'd0,    0); // R2 zero length
    push(va(4095, 0, 'h3FF), 1'b1, 32'h0008_0000, 13'd4096, 2); // R7 at maximum index
    push(va(4095, 0, 'h3FF), 1'b0, 32'h0008_0000, 13'd4096, 0); // R8 maximum frame
    push(va(3, 5, 'h001),   1'b0, 32'h0008_0000, 13'd4096, 1); // R4 absent entry

    repeat (3) @(negedge clk);
    chk("R12", "reqReady",    {31'b0, reqReady},    32'd1);
    chk("R12", "memReqValid", {31'b0, memReqValid}, 32'd0);
    chk("R12", "doneValid",   {31'b0, doneValid},   32'd0);
    chk("R12", "faultValid",  {31'b0, faultValid},  32'd0);
    rstN = 1'b1;

    while (!(reqQ.size() == 0 && phase == 0) && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      // compare this cycle's outputs with the model
      chk(phase == 0 ? "R1" : "R9", "reqReady", {31'b0, reqReady}, {31'b0, phase == 0});
      chk(phase == 1 ? "R3 R10" : (phase == 3 ? "R5 R11" : "R9 R11"), "memReqValid",
          {31'b0, memReqValid}, {31'b0, (phase == 1 || phase == 3)});
      if (phase == 1) chk("R3 R10", "outer address", memReqAddr, expAddr);
      if (phase == 3) chk("R5", "inner address", memReqAddr, expAddr);
      chk("R8", "doneValid", {31'b0, doneValid}, {31'b0, phase == 5});
      if (phase == 5) chk("R8", "donePaddr", donePaddr, expPaddr);
      chk(phase == 6 ? faultTag : "R9", "faultValid", {31'b0, faultValid}, {31'b0, phase == 6});
      if (phase == 6) begin
        chk(faultTag, "faultCode", {30'b0, faultCode}, {30'b0, expCode});
        chk(faultTag, "faultProt", {31'b0, faultProt}, {31'b0, expProt});
      end

      // drive the next cycle's inputs; busy cycles carry junk (R9 R10)
      reqValid = 1'b1; reqVaddr = 32'hFFFF_FFFF; reqWrite = 1'b1;
      tableBase = 32'hDEAD_0000; tableLen = 13'd0;
      memRespValid = 1'b0; memRespData = 32'h0;
      if (phase != 2 && phase != 4 && cyc[0]) begin
        memRespValid = 1'b1; memRespData = 32'hFFFF_FFFF; // stray response (R11)
      end

      case (phase)
        0: begin
          if (reqQ.size() != 0) begin
            cur = reqQ.pop_front();
            reqValid = 1'b1; reqVaddr = cur.va; reqWrite = cur.wr;
            tableBase = cur.base; tableLen = cur.len;
            if ({1'b0, cur.va[31:20]} >= cur.len) begin
              phase = 6; expCode = 2'b01; expProt = 1'b0; faultTag = "R2";
            end else begin
              phase = 1;
              expAddr = cur.base + {18'b0, cur.va[31:20], 2'b00};
            end
          end else begin
            reqValid = 1'b0;
          end
        end
        1: begin phase = 2; cnt = cur.dly; end
        2: begin
          if (cnt == 0) begin
            ent = rd(expAddr);
            memRespValid = 1'b1; memRespData = ent;
            if (!ent[0]) begin
              phase = 6; expCode = 2'b10; expProt = 1'b0; faultTag = "R4";
            end else begin
              outerEnt = ent; phase = 3;
              expAddr = {outerEnt[31:10], 10'b0} + {20'b0, cur.va[19:10], 2'b00};
            end
          end else cnt--;
        end
        3: begin phase = 4; cnt = cur.dly; end
        4: begin
          if (cnt == 0) begin
            ent = rd(expAddr);
            memRespValid = 1'b1; memRespData = ent;
            if (!ent[0]) begin
              phase = 6; expCode = 2'b11; expProt = 1'b0; faultTag = "R6";
            end else if (cur.wr && !ent[1]) begin
              phase = 6; expCode = 2'b11; expProt = 1'b1; faultTag = "R7";
            end else begin
              phase = 5; expPaddr = {ent[31:10], cur.va[9:0]};
            end
          end else cnt--;
        end
        default: phase = 0;
      endcase
    end

    if (cyc >= 20000) begin
      checks++; errors++;
      $display("FAIL R9 watchdog actual=%0d expected=<%0d cycles", cyc, 20000);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule